// File: doc/BRIEF.md
# UART Receive Queue with Flow-Control Hysteresis

This block is the buffer that sits behind the receive shift register of one UART channel. Each character the deframer completes arrives with three error tags: parity, framing and break. The block stores the character and its tags in a queue of `DEPTH` entries (64 by default). When the host turns the queue off, the block holds a single character instead. The oldest stored character always appears on the host read port. The tags of that character appear in the line-status bits, so a read of the byte and a read of its error state always refer to the same character.

The block also drives two signals for the host. The first is a receive interrupt, raised when the fill level reaches a host-programmed trigger. The second is an active-low request-to-send output for automatic flow control. This output stops the remote transmitter when the fill climbs above the trigger plus a hysteresis band. It lets the transmitter resume once the fill drops below the trigger minus the band. Both thresholds are clamped to the range 0 to `DEPTH`. Characters that arrive at a full buffer are dropped, and a sticky overrun flag records the loss.

Top module: `uart_rxq`

## Requirements
- R1: After reset the buffer is empty, `lsr` is 0, `rx_irq` is 0 and `rts_n` is 0.
- R2: With `fifo_en` high, `rd_data` shows the oldest stored character. A cycle with `rd_en` high removes exactly that character. `rd_en` on an empty buffer has no effect.
- R3: `lsr[0]` is 1 whenever at least one character is stored. `lsr[4:2]` equals the `char_err[2:0]` value that arrived with the character now on `rd_data`: bit 2 is parity, bit 3 is framing, bit 4 is break. `lsr[4:2]` reads 0 when the buffer is empty.
- R4: With `fifo_en` low, the buffer holds at most one character, and `rx_irq` is 1 whenever that character is present.
- R5: A character offered while the buffer is full (64 entries, or 1 entry with `fifo_en` low) is discarded, and stored contents are unchanged. `lsr[1]` is then set. It stays set until a cycle with `lsr_rd` high that has no new discard; a discard in that same cycle keeps it set.
- R6: With `fifo_en` high, `rx_irq` is 1 exactly when the fill level is at least the trigger. A trigger of 0 counts as 1, and a trigger above `DEPTH` counts as `DEPTH`.
- R7: With flow control active, `rts_n` goes to 1 one clock after the fill level is above min(`trig_lvl`+`hyst`, `DEPTH`).
- R8: With flow control active, `rts_n` goes to 0 one clock after the fill level is below max(`trig_lvl`-`hyst`, 0). Between the two thresholds it keeps its value.
- R9: Flow control is active only when both `auto_fc_en` and `mcr_fc_sel` are 1. Otherwise `rts_n` is 0 one clock later.
- R10: A `fifo_reset` pulse, or any change of `fifo_en`, empties the buffer at the next clock edge. After that edge `lsr[0]`, `lsr[4:2]` and `rx_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe: a completed character is offered |
| char_data | input | 8 | Received character |
| char_err | input | 3 | Tags for the character: [0] parity, [1] framing, [2] break |
| fifo_en | input | 1 | 1: queue of DEPTH entries, 0: single holding slot |
| fifo_reset | input | 1 | One-cycle pulse that empties the buffer |
| rd_en | input | 1 | Host read of the character on rd_data; removes it |
| rd_data | output | 8 | Oldest stored character |
| lsr_rd | input | 1 | Host read of line status; clears the overrun flag |
| lsr | output | 5 | [0] data ready, [1] overrun, [4:2] tags of the head character |
| trig_lvl | input | 7 | Receive trigger level (clog2(DEPTH)+1 bits) |
| hyst | input | 7 | Flow-control hysteresis band (clog2(DEPTH)+1 bits) |
| auto_fc_en | input | 1 | Enhanced-feature enable for automatic flow control |
| mcr_fc_sel | input | 1 | Modem-control select for automatic flow control |
| rx_irq | output | 1 | Receive data interrupt |
| rts_n | output | 1 | Active-low request-to-send / terminal-ready flow output |

## Verification
The assertions assume that `char_valid`, `rd_en`, `lsr_rd` and `fifo_reset` are synchronous to `clk`. They also assume the threshold inputs hold steady during the cycle they are sampled, and that `DEPTH` stays below 128 so the 8-bit threshold arithmetic cannot wrap. The bench drives every input on the falling edge and holds the trigger and band constant while it fills or drains the buffer. It uses 7-bit values only. It walks the fill level across each threshold one character at a time, so every change of `rts_n` and `rx_irq` can be tied to a single write or read.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  localparam int TAG_W = 3;
  localparam int ENTRY_W = 8 + TAG_W;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [7:0]       data;
  } rxq_entry_t;

  // upper flow-control threshold: trigger plus band, clamped to depth
  function automatic logic [7:0] fc_high(input logic [7:0] trig,
                                         input logic [7:0] band,
                                         input logic [7:0] depth);
    logic [8:0] sum;
    sum = {1'b0, trig} + {1'b0, band};
    return (sum > {1'b0, depth}) ? depth : sum[7:0];
  endfunction

  // lower flow-control threshold: trigger minus band, clamped to 0..depth
  function automatic logic [7:0] fc_low(input logic [7:0] trig,
                                        input logic [7:0] band,
                                        input logic [7:0] depth);
    logic [7:0] diff;
    diff = (trig > band) ? (trig - band) : 8'd0;
    return (diff > depth) ? depth : diff;
  endfunction

  // interrupt level: trigger clamped to 1..depth
  function automatic logic [7:0] irq_level(input logic [7:0] trig,
                                           input logic [7:0] depth);
    if (trig == 8'd0) return 8'd1;
    return (trig > depth) ? depth : trig;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 64,
  parameter int DW = 11,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          cap_one,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_word,
  input  logic          rd_req,
  output logic [DW-1:0] head_word,
  output logic [CW-1:0] level,
  output logic          wr_drop,
  output logic          rd_pop
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cap;
  logic          wr_fire;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap     = cap_one ? CW'(1) : CW'(DEPTH);
  assign wr_fire = wr_req && !flush && (cnt_q < cap);
  assign wr_drop = wr_req && !flush && (cnt_q >= cap);
  assign rd_pop  = rd_req && !flush && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp_q] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_fire) wp_q <= bump(wp_q);
      if (rd_pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(wr_fire) - CW'(rd_pop);
    end
  end

  assign head_word = mem[rp_q];
  assign level     = cnt_q;

  a_r5_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  a_r2_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !wr_fire) |=> (level == $past(level) - 1'b1));

  a_r5_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !rd_pop) |=> (level == $past(level)));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             wr_drop,
  input  logic             lsr_rd,
  input  logic [CW-1:0]    level,
  input  logic [TAG_W-1:0] head_tag,
  input  logic [CW-1:0]    trig,
  output logic [4:0]       lsr,
  output logic             irq
);

  localparam logic [7:0] DEP8 = 8'(DEPTH);

  logic       ovr_q;
  logic       data_rdy;
  logic [7:0] lvl8, thr8;

  assign lvl8     = 8'(level);
  assign thr8     = irq_level(8'(trig), DEP8);
  assign data_rdy = (level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (wr_drop) ovr_q <= 1'b1;
    else if (lsr_rd)  ovr_q <= 1'b0;
  end

  assign lsr = {data_rdy ? head_tag : {TAG_W{1'b0}}, ovr_q, data_rdy};
  assign irq = fifo_mode ? (lvl8 >= thr8) : data_rdy;

  a_r5_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> lsr[1]);

  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[1] && !lsr_rd) |=> lsr[1]);

  a_r6_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (level != '0));

  a_r3_tags_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (lsr[4:2] == '0));

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fc_on,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] trig,
  input  logic [CW-1:0] band,
  output logic          rts_n
);

  localparam logic [7:0] DEP8 = 8'(DEPTH);

  logic       go_q, go_d;
  logic [7:0] lvl8, hi8, lo8;
  logic       above_hi, below_lo;

  assign lvl8     = 8'(level);
  assign hi8      = fc_high(8'(trig), 8'(band), DEP8);
  assign lo8      = fc_low(8'(trig), 8'(band), DEP8);
  assign above_hi = lvl8 > hi8;
  assign below_lo = lvl8 < lo8;

  always_comb begin
    if (!fc_on)        go_d = 1'b1;
    else if (above_hi) go_d = 1'b0;
    else if (below_lo) go_d = 1'b1;
    else               go_d = go_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b1;
    else        go_q <= go_d;
  end

  assign rts_n = ~go_q;

  a_r7_stop_above: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && above_hi) |=> rts_n);

  a_r8_resume_below: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && below_lo) |=> !rts_n);

  a_r8_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && !above_hi && !below_lo) |=> $stable(rts_n));

  a_r9_off_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_on |=> !rts_n);

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_valid,
  input  logic [7:0]    char_data,
  input  logic [2:0]    char_err,
  input  logic          fifo_en,
  input  logic          fifo_reset,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          lsr_rd,
  output logic [4:0]    lsr,
  input  logic [CW-1:0] trig_lvl,
  input  logic [CW-1:0] hyst,
  input  logic          auto_fc_en,
  input  logic          mcr_fc_sel,
  output logic          rx_irq,
  output logic          rts_n
);

  logic          en_q;
  logic          flush;
  logic          fc_on;
  rxq_entry_t    in_word, head;
  logic [CW-1:0] level;
  logic          wr_drop, rd_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign flush   = fifo_reset || (fifo_en != en_q);
  assign fc_on   = auto_fc_en && mcr_fc_sel;
  assign in_word = '{tag: char_err, data: char_data};

  rxq_store #(.DEPTH(DEPTH), .DW(ENTRY_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .cap_one  (!fifo_en),
    .wr_req   (char_valid),
    .wr_word  (in_word),
    .rd_req   (rd_en),
    .head_word(head),
    .level    (level),
    .wr_drop  (wr_drop),
    .rd_pop   (rd_pop)
  );

  rxq_status #(.DEPTH(DEPTH)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_mode(fifo_en),
    .wr_drop  (wr_drop),
    .lsr_rd   (lsr_rd),
    .level    (level),
    .head_tag (head.tag),
    .trig     (trig_lvl),
    .lsr      (lsr),
    .irq      (rx_irq)
  );

  rxq_flow #(.DEPTH(DEPTH)) u_flow (
    .clk  (clk),
    .rst_n(rst_n),
    .fc_on(fc_on),
    .level(level),
    .trig (trig_lvl),
    .band (hyst),
    .rts_n(rts_n)
  );

  assign rd_data = head.data;

  a_r4_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !en_q) |-> (level <= CW'(1)));

  a_r4_irq_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && lsr[0]) |-> rx_irq);

  a_r2_empty_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !lsr[0] && !char_valid && !flush) |=> !lsr[0]);

endmodule

// File: tb/uart_rxq_test.sv
module uart_rxq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_valid = 1'b0;
  logic [7:0] char_data = '0;
  logic [2:0] char_err = '0;
  logic       fifo_en = 1'b0;
  logic       fifo_reset = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       lsr_rd = 1'b0;
  logic [4:0] lsr;
  logic [6:0] trig_lvl = '0;
  logic [6:0] hyst = '0;
  logic       auto_fc_en = 1'b0;
  logic       mcr_fc_sel = 1'b0;
  logic       rx_irq;
  logic       rts_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [10:0] sb[$];

  always #10 clk = ~clk;

  uart_rxq uut (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .char_err(char_err), .fifo_en(fifo_en), .fifo_reset(fifo_reset),
    .rd_en(rd_en), .rd_data(rd_data), .lsr_rd(lsr_rd), .lsr(lsr),
    .trig_lvl(trig_lvl), .hyst(hyst), .auto_fc_en(auto_fc_en),
    .mcr_fc_sel(mcr_fc_sel), .rx_irq(rx_irq), .rts_n(rts_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // driver: offers a character and records what the queue must hold
  task automatic push(input logic [7:0] d, input logic [2:0] e);
    int cap;
    cap = fifo_en ? 64 : 1;
    char_data = d;
    char_err = e;
    char_valid = 1'b1;
    tick();
    char_valid = 1'b0;
    if (sb.size() < cap) sb.push_back({e, d});
  endtask

  // monitor: compares the head against the scoreboard, then consumes it
  task automatic pop_chk(input string req);
    logic [10:0] exp;
    if (sb.size() == 0) begin
      check(req, "scoreboard underflow", 1, 0);
      return;
    end
    exp = sb.pop_front();
    check(req, "rd_data", int'(rd_data), int'(exp[7:0]));
    check("R3", "lsr tags", int'(lsr[4:2]), int'(exp[10:8]));
    check("R3", "data ready", int'(lsr[0]), 1);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic clear_ovr();
    lsr_rd = 1'b1;
    tick();
    lsr_rd = 1'b0;
  endtask

  task automatic flush_pulse();
    fifo_reset = 1'b1;
    tick();
    fifo_reset = 1'b0;
    sb.delete();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1", "lsr", int'(lsr), 0);
    check("R1", "rx_irq", int'(rx_irq), 0);
    check("R1", "rts_n", int'(rts_n), 0);
    // R2 read of empty buffer does nothing
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R2", "lsr after empty read", int'(lsr), 0);

    // queue mode, trigger 4
    fifo_en = 1'b1;
    trig_lvl = 7'd4;
    tick();
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i), 3'(i + 1));
    check("R6", "irq below trigger", int'(rx_irq), 0);
    push(8'h13, 3'd4);
    check("R6", "irq at trigger", int'(rx_irq), 1);
    pop_chk("R2");
    check("R6", "irq after drop below", int'(rx_irq), 0);
    while (sb.size() != 0) pop_chk("R2");
    check("R3", "lsr empty", int'(lsr), 0);

    // full queue and overrun, R5
    trig_lvl = 7'd64;
    for (int i = 0; i < 64; i++) push(8'(i * 3), 3'(i));
    check("R6", "irq at 64", int'(rx_irq), 1);
    push(8'hEE, 3'd7);
    check("R5", "overrun set", int'(lsr[1]), 1);
    tick();
    check("R5", "overrun sticky", int'(lsr[1]), 1);
    clear_ovr();
    check("R5", "overrun cleared", int'(lsr[1]), 0);
    lsr_rd = 1'b1;
    push(8'hED, 3'd7);
    lsr_rd = 1'b0;
    check("R5", "drop beats status read", int'(lsr[1]), 1);
    clear_ovr();
    while (sb.size() != 0) pop_chk("R5");
    check("R5", "no dropped byte left", int'(lsr[0]), 0);

    // flow control, trigger 48 band 8
    trig_lvl = 7'd48;
    hyst = 7'd8;
    auto_fc_en = 1'b1;
    mcr_fc_sel = 1'b1;
    for (int i = 0; i < 56; i++) push(8'(i), 3'd0);
    tick();
    check("R7", "rts at 56", int'(rts_n), 0);
    push(8'h80, 3'd1);
    tick();
    check("R7", "rts above 56", int'(rts_n), 1);
    for (int i = 0; i < 17; i++) pop_chk("R8");
    tick();
    check("R8", "rts held at 40", int'(rts_n), 1);
    pop_chk("R8");
    tick();
    check("R8", "rts below 40", int'(rts_n), 0);
    for (int i = 0; i < 18; i++) push(8'h90, 3'd2);
    tick();
    check("R7", "rts refill", int'(rts_n), 1);
    mcr_fc_sel = 1'b0;
    tick();
    tick();
    check("R9", "rts with one enable", int'(rts_n), 0);
    mcr_fc_sel = 1'b1;
    tick();
    tick();
    check("R9", "rts both enables", int'(rts_n), 1);
    flush_pulse();
    check("R10", "lsr after reset pulse", int'(lsr), 0);
    check("R10", "irq after reset pulse", int'(rx_irq), 0);
    tick();
    check("R8", "rts after empty", int'(rts_n), 0);
    auto_fc_en = 1'b0;

    // single holding slot, R4
    fifo_en = 1'b0;
    tick();
    sb.delete();
    push(8'hA5, 3'd5);
    check("R4", "irq one byte", int'(rx_irq), 1);
    check("R3", "tags single", int'(lsr[4:2]), 5);
    push(8'h5A, 3'd2);
    check("R4", "second byte overruns", int'(lsr[1]), 1);
    pop_chk("R4");
    check("R4", "irq after read", int'(rx_irq), 0);
    clear_ovr();

    // enable change flushes, R10
    push(8'h77, 3'd1);
    fifo_en = 1'b1;
    tick();
    sb.delete();
    check("R10", "enable change empties", int'(lsr[0]), 0);

    // trigger 0 acts as 1, R6
    trig_lvl = 7'd0;
    hyst = 7'd0;
    tick();
    check("R6", "irq empty trig0", int'(rx_irq), 0);
    push(8'h42, 3'd3);
    check("R6", "irq one byte trig0", int'(rx_irq), 1);
    pop_chk("R2");

    // clamped thresholds
    trig_lvl = 7'd60;
    hyst = 7'd10;
    auto_fc_en = 1'b1;
    for (int i = 0; i < 64; i++) push(8'(255 - i), 3'(i));
    tick();
    check("R7", "high clamp to 64", int'(rts_n), 0);
    trig_lvl = 7'd5;
    tick();
    tick();
    check("R7", "stop above 15", int'(rts_n), 1);
    while (sb.size() != 0) pop_chk("R2");
    tick();
    check("R8", "low clamp to 0 holds", int'(rts_n), 1);
    flush_pulse();
    finish_run();
  end

endmodule